// File: doc/BRIEF.md
# Layered Fetch Redirect Predictor

This block chooses, once per cycle, the address the instruction fetch unit reads next. Four sources can steer fetch, and a fixed priority decides between them when more than one is active. The latest-stage source takes precedence. A second-stage address calculator correction wins over a first-stage one. Either correction wins over a return stack prediction, which in turn wins over a match in the small table of software-loaded target registers. When nothing is active, fetch moves on sequentially by two 16-byte bundles.

Each redirect carries the number of fetch bubbles it costs, so the downstream fetch queue can account for the lost slots:

| Source | Bubbles |
|---|---|
| Target-register hit | 0 |
| Return stack | 1 |
| First calculator | 2 |
| Second calculator | 3 |

All three outputs are registered and reflect the inputs presented one clock earlier. The target registers and the return stack update from their own load, call and return inputs, whatever source wins the arbitration.

Top module: `fetch_steer`

## Requirements
- R1: After a synchronous reset, `next_pc_o` is `RESET_PC` (0), `redirect_o` is 0 and `bubble_o` is 0. The target table and the return stack are empty.
- R2: If no source is active in a cycle, then in the following cycle `next_pc_o` equals that cycle's `pc_i` plus 32, `redirect_o` is 0 and `bubble_o` is 0.
- R3: If `pc_i` equals the branch address of a valid target entry, the following cycle shows that entry's target with `redirect_o`=1 and `bubble_o`=0. Matching uses the table contents from before any load in the same cycle.
- R4: A load whose branch address equals that of a valid entry rewrites that entry's target in place. The replacement pointer does not advance.
- R5: A load of a new branch address writes the entry under a round-robin pointer. The pointer starts at entry 0 and advances by one per such load, modulo 4. A fifth distinct load therefore evicts the first.
- R6: A return (`ret_i`) with a non-empty stack predicts the most recently pushed address with `redirect_o`=1 and `bubble_o`=1, and pops it.
- R7: The return stack holds 8 entries in LIFO order. A push when full overwrites the oldest entry and leaves the depth at 8. After 9 pushes, 8 returns yield pushes 9 down to 2, and the stack is then empty.
- R8: A return on an empty stack gives no prediction. The cycle resolves as if `ret_i` were low, falling to a target hit or to the sequential address.
- R9: A first-calculator correction (`bac1_fix_i`) yields `bac1_tgt_i` with `bubble_o`=2. It overrides return stack and target-register redirects.
- R10: A second-calculator correction (`bac2_fix_i`) yields `bac2_tgt_i` with `bubble_o`=3. It overrides every other source.
- R11: A call and a return in the same cycle predict the current top, then replace the top with the call's return address. The depth is unchanged.
- R12: Calls and returns update the stack even when a calculator correction wins that cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| pc_i | input | AW | Current fetch address |
| tar_ld_i | input | 1 | Load one target register entry |
| tar_br_i | input | AW | Branch instruction address for the load |
| tar_tgt_i | input | AW | Branch target for the load |
| call_i | input | 1 | Procedure call seen; push return address |
| call_ret_i | input | AW | Return address to push |
| ret_i | input | 1 | Procedure return seen; pop and predict |
| bac1_fix_i | input | 1 | First-stage calculator correction |
| bac1_tgt_i | input | AW | First-stage corrected target |
| bac2_fix_i | input | 1 | Second-stage calculator correction |
| bac2_tgt_i | input | AW | Second-stage corrected target |
| next_pc_o | output | AW | Registered next fetch address |
| redirect_o | output | 1 | Registered: next address is not sequential |
| bubble_o | output | 2 | Registered bubble cost of the redirect |

## Verification
The scoreboard drives the selector with these patterns:

- Plain sequential addresses, to separate the no-source path from every redirect.
- Target-register hits before and after an in-place update and a round-robin eviction, to show which entry a load touched.
- Call/return sequences that are nested, that overflow and that underflow, to tell LIFO order and oldest-entry overwrite apart from a plain FIFO or a saturating stack.
- Stacked sources in one cycle (target hit plus return plus both corrections), to expose the priority order and the bubble count of the winner.
- Returns hidden behind corrections, to show that stack state still moves.

// File: rtl/fsp_pkg.sv
package fsp_pkg;
  typedef enum logic [2:0] {
    SRC_SEQ  = 3'd0,
    SRC_TAR  = 3'd1,
    SRC_RET  = 3'd2,
    SRC_BAC1 = 3'd3,
    SRC_BAC2 = 3'd4
  } src_e;

  function automatic logic [1:0] bubble_of(src_e s);
    case (s)
      SRC_RET:  return 2'd1;
      SRC_BAC1: return 2'd2;
      SRC_BAC2: return 2'd3;
      default:  return 2'd0;
    endcase
  endfunction
endpackage

// File: rtl/fsp_tar_bank.sv
module fsp_tar_bank #(
  parameter int AW = 32,
  parameter int N  = 4
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          ld_i,
  input  logic [AW-1:0] ld_br_i,
  input  logic [AW-1:0] ld_tgt_i,
  input  logic [AW-1:0] pc_i,
  output logic          hit_o,
  output logic [AW-1:0] hit_tgt_o
);
  localparam int IW = (N > 1) ? $clog2(N) : 1;

  logic [N-1:0]  vld_q;
  logic [AW-1:0] br_q  [N];
  logic [AW-1:0] tgt_q [N];
  logic [IW-1:0] rr_q;
  logic [N-1:0]  hit_v, same_v;
  logic [IW-1:0] wr_idx;
  logic          same_any;

  for (genvar g = 0; g < N; g++) begin : g_cmp
    assign hit_v[g]  = vld_q[g] && (br_q[g] == pc_i);
    assign same_v[g] = vld_q[g] && (br_q[g] == ld_br_i);
  end

  assign hit_o    = |hit_v;
  assign same_any = |same_v;

  always_comb begin
    hit_tgt_o = '0;
    wr_idx    = rr_q;
    for (int i = N - 1; i >= 0; i--) begin
      if (hit_v[i])  hit_tgt_o = tgt_q[i];
      if (same_v[i]) wr_idx    = IW'(i);
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      vld_q <= '0;
      rr_q  <= '0;
    end else if (ld_i) begin
      vld_q[wr_idx] <= 1'b1;
      if (!same_any) rr_q <= (rr_q == IW'(N - 1)) ? '0 : rr_q + 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (ld_i) begin
      br_q[wr_idx]  <= ld_br_i;
      tgt_q[wr_idx] <= ld_tgt_i;
    end
  end
endmodule

// File: rtl/fsp_ret_stack.sv
module fsp_ret_stack #(
  parameter int AW    = 32,
  parameter int DEPTH = 8
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic                       push_i,
  input  logic [AW-1:0]              push_addr_i,
  input  logic                       pop_i,
  output logic                       pop_vld_o,
  output logic [AW-1:0]              pop_tgt_o,
  output logic [$clog2(DEPTH+1)-1:0] cnt_o
);
  localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = $clog2(DEPTH + 1);

  logic [AW-1:0] mem [DEPTH];
  logic [PW-1:0] wp_q, top_idx, wp_inc;
  logic [CW-1:0] cnt_q;
  logic          pop_ok;

  assign top_idx   = (wp_q == '0) ? PW'(DEPTH - 1) : wp_q - 1'b1;
  assign wp_inc    = (wp_q == PW'(DEPTH - 1)) ? '0 : wp_q + 1'b1;
  assign pop_ok    = pop_i && (cnt_q != '0);
  assign pop_vld_o = pop_ok;
  assign pop_tgt_o = mem[top_idx];
  assign cnt_o     = cnt_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      wp_q  <= '0;
      cnt_q <= '0;
    end else if (push_i && !pop_ok) begin
      wp_q  <= wp_inc;
      if (cnt_q != CW'(DEPTH)) cnt_q <= cnt_q + 1'b1;
    end else if (pop_ok && !push_i) begin
      wp_q  <= top_idx;
      cnt_q <= cnt_q - 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (push_i) begin
      if (pop_ok) mem[top_idx] <= push_addr_i;
      else        mem[wp_q]    <= push_addr_i;
    end
  end
endmodule

// File: rtl/fsp_src_select.sv
module fsp_src_select
  import fsp_pkg::*;
#(
  parameter int AW   = 32,
  parameter int STEP = 32
) (
  input  logic [AW-1:0] pc_i,
  input  logic          tar_hit_i,
  input  logic [AW-1:0] tar_tgt_i,
  input  logic          ret_vld_i,
  input  logic [AW-1:0] ret_tgt_i,
  input  logic          bac1_i,
  input  logic [AW-1:0] bac1_tgt_i,
  input  logic          bac2_i,
  input  logic [AW-1:0] bac2_tgt_i,
  output src_e          src_o,
  output logic [AW-1:0] nxt_o
);
  always_comb begin
    if (bac2_i) begin
      src_o = SRC_BAC2; nxt_o = bac2_tgt_i;
    end else if (bac1_i) begin
      src_o = SRC_BAC1; nxt_o = bac1_tgt_i;
    end else if (ret_vld_i) begin
      src_o = SRC_RET;  nxt_o = ret_tgt_i;
    end else if (tar_hit_i) begin
      src_o = SRC_TAR;  nxt_o = tar_tgt_i;
    end else begin
      src_o = SRC_SEQ;  nxt_o = pc_i + AW'(STEP);
    end
  end
endmodule

// File: rtl/fetch_steer.sv
module fetch_steer
  import fsp_pkg::*;
#(
  parameter int          AW       = 32,
  parameter int          N_TAR    = 4,
  parameter int          RS_DEPTH = 8,
  parameter int          STEP     = 32,
  parameter logic [31:0] RESET_PC = 32'h0
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [AW-1:0] pc_i,
  input  logic          tar_ld_i,
  input  logic [AW-1:0] tar_br_i,
  input  logic [AW-1:0] tar_tgt_i,
  input  logic          call_i,
  input  logic [AW-1:0] call_ret_i,
  input  logic          ret_i,
  input  logic          bac1_fix_i,
  input  logic [AW-1:0] bac1_tgt_i,
  input  logic          bac2_fix_i,
  input  logic [AW-1:0] bac2_tgt_i,
  output logic [AW-1:0] next_pc_o,
  output logic          redirect_o,
  output logic [1:0]    bubble_o
);
  localparam int CW = $clog2(RS_DEPTH + 1);

  logic          tar_hit;
  logic [AW-1:0] tar_tgt;
  logic          ret_vld;
  logic [AW-1:0] ret_tgt;
  logic [CW-1:0] rs_cnt;
  src_e          src;
  logic [AW-1:0] nxt;

  fsp_tar_bank #(.AW(AW), .N(N_TAR)) u_tar (
    .clk(clk), .rst(rst), .ld_i(tar_ld_i), .ld_br_i(tar_br_i),
    .ld_tgt_i(tar_tgt_i), .pc_i(pc_i), .hit_o(tar_hit), .hit_tgt_o(tar_tgt)
  );

  fsp_ret_stack #(.AW(AW), .DEPTH(RS_DEPTH)) u_rs (
    .clk(clk), .rst(rst), .push_i(call_i), .push_addr_i(call_ret_i),
    .pop_i(ret_i), .pop_vld_o(ret_vld), .pop_tgt_o(ret_tgt), .cnt_o(rs_cnt)
  );

  fsp_src_select #(.AW(AW), .STEP(STEP)) u_sel (
    .pc_i(pc_i), .tar_hit_i(tar_hit), .tar_tgt_i(tar_tgt),
    .ret_vld_i(ret_vld), .ret_tgt_i(ret_tgt),
    .bac1_i(bac1_fix_i), .bac1_tgt_i(bac1_tgt_i),
    .bac2_i(bac2_fix_i), .bac2_tgt_i(bac2_tgt_i),
    .src_o(src), .nxt_o(nxt)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      next_pc_o  <= AW'(RESET_PC);
      redirect_o <= 1'b0;
      bubble_o   <= 2'd0;
    end else begin
      next_pc_o  <= nxt;
      redirect_o <= (src != SRC_SEQ);
      bubble_o   <= bubble_of(src);
    end
  end
endmodule

// File: rtl/fsp_checker.sv
module fsp_checker #(
  parameter int AW    = 32,
  parameter int STEP  = 32,
  parameter int DEPTH = 8
) (
  input logic                       clk,
  input logic                       rst,
  input logic [AW-1:0]              pc_i,
  input logic                       call_i,
  input logic                       ret_i,
  input logic                       bac1_fix_i,
  input logic [AW-1:0]              bac1_tgt_i,
  input logic                       bac2_fix_i,
  input logic [AW-1:0]              bac2_tgt_i,
  input logic [AW-1:0]              next_pc_o,
  input logic                       redirect_o,
  input logic [1:0]                 bubble_o,
  input logic [$clog2(DEPTH+1)-1:0] rs_cnt
);
  logic armed;
  always_ff @(posedge clk) armed <= !rst;

  AST_SEQ_STEP: assert property (@(posedge clk) disable iff (rst)
    armed && !redirect_o |-> next_pc_o == $past(pc_i) + AW'(STEP) && bubble_o == 2'd0); // R2

  AST_BAC2_WINS: assert property (@(posedge clk) disable iff (rst)
    bac2_fix_i |=> redirect_o && bubble_o == 2'd3 && next_pc_o == $past(bac2_tgt_i)); // R10

  AST_BAC1_COST: assert property (@(posedge clk) disable iff (rst)
    bac1_fix_i && !bac2_fix_i |=> redirect_o && bubble_o == 2'd2 && next_pc_o == $past(bac1_tgt_i)); // R9

  AST_EMPTY_POP: assert property (@(posedge clk) disable iff (rst)
    ret_i && !call_i && rs_cnt == '0 && !bac1_fix_i && !bac2_fix_i |=> bubble_o != 2'd1); // R8

  AST_FULL_PUSH: assert property (@(posedge clk) disable iff (rst)
    call_i && !ret_i && rs_cnt == DEPTH |=> rs_cnt == DEPTH); // R7

  AST_PAIR_KEEP: assert property (@(posedge clk) disable iff (rst)
    call_i && ret_i |=> $stable(rs_cnt)); // R11
endmodule

bind fetch_steer fsp_checker #(.AW(AW), .STEP(STEP), .DEPTH(RS_DEPTH)) u_chk (
  .clk(clk), .rst(rst), .pc_i(pc_i), .call_i(call_i), .ret_i(ret_i),
  .bac1_fix_i(bac1_fix_i), .bac1_tgt_i(bac1_tgt_i),
  .bac2_fix_i(bac2_fix_i), .bac2_tgt_i(bac2_tgt_i),
  .next_pc_o(next_pc_o), .redirect_o(redirect_o), .bubble_o(bubble_o),
  .rs_cnt(rs_cnt)
);

// File: tb/sim_fetch_steer.sv
`timescale 1ns/1ps
module sim_fetch_steer;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [31:0] pc_i = '0;
  logic        tar_ld_i = 1'b0;
  logic [31:0] tar_br_i = '0, tar_tgt_i = '0;
  logic        call_i = 1'b0;
  logic [31:0] call_ret_i = '0;
  logic        ret_i = 1'b0;
  logic        bac1_fix_i = 1'b0, bac2_fix_i = 1'b0;
  logic [31:0] bac1_tgt_i = '0, bac2_tgt_i = '0;
  logic [31:0] next_pc_o;
  logic        redirect_o;
  logic [1:0]  bubble_o;

  int n_run = 0, n_fail = 0, cyc = 0;

  typedef struct {
    logic [31:0] pc;
    logic        rd;
    logic [1:0]  bb;
    string       tag;
  } exp_t;
  exp_t sb[$];

  always #2.5 clk = ~clk;

  fetch_steer u0 (
    .clk(clk), .rst(rst), .pc_i(pc_i), .tar_ld_i(tar_ld_i), .tar_br_i(tar_br_i),
    .tar_tgt_i(tar_tgt_i), .call_i(call_i), .call_ret_i(call_ret_i), .ret_i(ret_i),
    .bac1_fix_i(bac1_fix_i), .bac1_tgt_i(bac1_tgt_i), .bac2_fix_i(bac2_fix_i),
    .bac2_tgt_i(bac2_tgt_i), .next_pc_o(next_pc_o), .redirect_o(redirect_o),
    .bubble_o(bubble_o)
  );

  // Monitor: one expectation per clock edge, sampled 1 ns after the edge.
  always @(posedge clk) begin
    #1;
    if (sb.size() > 0) begin
      exp_t e;
      e = sb.pop_front();
      n_run++;
      if (next_pc_o !== e.pc || redirect_o !== e.rd || bubble_o !== e.bb) begin
        n_fail++;
        $display("FAIL %s: got pc=%h rd=%0d bb=%0d exp pc=%h rd=%0d bb=%0d",
                 e.tag, next_pc_o, redirect_o, bubble_o, e.pc, e.rd, e.bb);
      end
    end
  end

  // Driver: inputs are set right after a negedge, then step() records the expectation.
  task automatic step(input string tag, input logic [31:0] epc,
                      input logic erd, input logic [1:0] ebb);
    exp_t e;
    e.pc = epc; e.rd = erd; e.bb = ebb; e.tag = tag;
    sb.push_back(e);
    @(negedge clk);
    tar_ld_i = 1'b0; call_i = 1'b0; ret_i = 1'b0;
    bac1_fix_i = 1'b0; bac2_fix_i = 1'b0;
  endtask

  task automatic tload(input logic [31:0] br, input logic [31:0] tg);
    pc_i = 32'h0; tar_ld_i = 1'b1; tar_br_i = br; tar_tgt_i = tg;
    step("R5_load", 32'h20, 1'b0, 2'd0);
  endtask

  task automatic push(input logic [31:0] a);
    pc_i = 32'h40; call_i = 1'b1; call_ret_i = a;
    step("R7_push", 32'h60, 1'b0, 2'd0);
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 100000) begin
      n_fail++;
      $display("FAIL watchdog: got cycle=%0d exp below 100000", cyc);
      $display("[TB] %0d tests run, %0d failed", n_run + 1, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    n_run++;
    if (next_pc_o !== 32'h0 || redirect_o !== 1'b0 || bubble_o !== 2'd0) begin
      n_fail++;
      $display("FAIL R1 reset: got pc=%h rd=%0d bb=%0d exp pc=0 rd=0 bb=0",
               next_pc_o, redirect_o, bubble_o);
    end
    rst = 1'b0;

    // R2 sequential
    pc_i = 32'h1000; step("R2_seq_a", 32'h1020, 1'b0, 2'd0);
    pc_i = 32'h2040; step("R2_seq_b", 32'h2060, 1'b0, 2'd0);
    // R1: empty table and stack give no redirect
    pc_i = 32'h1100; ret_i = 1'b1; step("R1_empty", 32'h1120, 1'b0, 2'd0);

    // R3 TAR hit; same-cycle load not visible
    pc_i = 32'h1100; tar_ld_i = 1'b1; tar_br_i = 32'h1100; tar_tgt_i = 32'h5000;
    step("R3_load_same_cycle", 32'h1120, 1'b0, 2'd0);
    pc_i = 32'h1100; step("R3_hit", 32'h5000, 1'b1, 2'd0);

    // R4 in-place update
    tload(32'h1100, 32'h6000);
    pc_i = 32'h1100; step("R4_inplace", 32'h6000, 1'b1, 2'd0);

    // R5 round robin: entries 1..3, then entry 0 evicted
    tload(32'h1200, 32'h7200);
    tload(32'h1300, 32'h7300);
    tload(32'h1400, 32'h7400);
    tload(32'h1500, 32'h7500);
    pc_i = 32'h1100; step("R5_evicted", 32'h1120, 1'b0, 2'd0);
    pc_i = 32'h1500; step("R5_new", 32'h7500, 1'b1, 2'd0);
    pc_i = 32'h1200; step("R5_kept", 32'h7200, 1'b1, 2'd0);

    // R6 returns
    push(32'hA000);
    push(32'hB000);
    pc_i = 32'h0; ret_i = 1'b1; step("R6_ret_b", 32'hB000, 1'b1, 2'd1);
    pc_i = 32'h0; ret_i = 1'b1; step("R6_ret_a", 32'hA000, 1'b1, 2'd1);
    // R8 empty pop falls through
    pc_i = 32'h1200; ret_i = 1'b1; step("R8_empty_tar", 32'h7200, 1'b1, 2'd0);
    pc_i = 32'h0100; ret_i = 1'b1; step("R8_empty_seq", 32'h0120, 1'b0, 2'd0);
    // R6 return beats TAR
    push(32'hA800);
    pc_i = 32'h1300; ret_i = 1'b1; step("R6_over_tar", 32'hA800, 1'b1, 2'd1);

    // R7 overflow
    for (int i = 1; i <= 9; i++) push(32'hC000 + 32'(i) * 32'h10);
    for (int i = 9; i >= 2; i--) begin
      pc_i = 32'h0; ret_i = 1'b1;
      step("R7_lifo", 32'hC000 + 32'(i) * 32'h10, 1'b1, 2'd1);
    end
    pc_i = 32'h0; ret_i = 1'b1; step("R7_drained", 32'h20, 1'b0, 2'd0);

    // R9 first calculator over TAR and return; R12 stack still pops
    pc_i = 32'h1200; bac1_fix_i = 1'b1; bac1_tgt_i = 32'hD000;
    step("R9_over_tar", 32'hD000, 1'b1, 2'd2);
    push(32'hE000);
    push(32'hE100);
    pc_i = 32'h0; ret_i = 1'b1; bac1_fix_i = 1'b1; bac1_tgt_i = 32'hD100;
    step("R9_over_ret", 32'hD100, 1'b1, 2'd2);
    pc_i = 32'h0; ret_i = 1'b1; step("R12_popped", 32'hE000, 1'b1, 2'd1);

    // R10 second calculator over all
    push(32'hE200);
    pc_i = 32'h1200; ret_i = 1'b1; bac1_fix_i = 1'b1; bac1_tgt_i = 32'hD200;
    bac2_fix_i = 1'b1; bac2_tgt_i = 32'hF000;
    step("R10_over_all", 32'hF000, 1'b1, 2'd3);
    pc_i = 32'h0; ret_i = 1'b1; step("R12_empty_after", 32'h20, 1'b0, 2'd0);

    // R11 call and return together
    push(32'h9000);
    pc_i = 32'h0; call_i = 1'b1; call_ret_i = 32'h9100; ret_i = 1'b1;
    step("R11_pair", 32'h9000, 1'b1, 2'd1);
    pc_i = 32'h0; ret_i = 1'b1; step("R11_replaced", 32'h9100, 1'b1, 2'd1);
    pc_i = 32'h0; ret_i = 1'b1; step("R11_depth", 32'h20, 1'b0, 2'd0);

    pc_i = 32'h3000; step("R2_tail", 32'h3020, 1'b0, 2'd0);
    repeat (2) @(negedge clk);
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule